// File: doc/BRIEF.md
# Codec Variable-Rate Slot Request Generator

This block sits on the codec side of a 48 kHz serial audio link. Once per link frame it decides which of the controller-to-codec audio slots ask for a sample in the following frame. It also decides which of the tagged samples that arrive in the current frame go into the per-channel FIFOs. The request vector is active low. A 0 in slot position n asks the controller to fill slot n in the next outgoing frame. In that next frame the codec then looks at the tag for slot n to see whether the sample really came.

Each slot has one of three classes, set at build time, plus a supported flag. Primary PCM slots follow the `vra` mode bit. Auxiliary slots follow the `vrm` mode bit. Modem-type slots always work on demand. A slot in fixed mode asks for data in every frame. A slot in on-demand mode is paced by a phase accumulator that adds the slot's programmed rate once per frame. It also checks that the slot's FIFO has room. Powered-down and unsupported slots drop out of the frame. After power-down is released, a programmable number of frames passes during which the slot reports "not ready" before it starts requesting.

Top module: `vsr_slot_req_top`

## Requirements
- R1: After reset, `slotreq_n`, `accept` and `overrun` are all 0.
- R2: With `vra`=0, a ready, powered-up PCM-class slot drives its `slotreq_n` bit to 0 on every frame. Its programmed rate has no effect.
- R3: A ready on-demand slot adds min(rate, 48000) to its accumulator on each frame strobe. It requests (bit 0) only on frames where the sum reaches 48000, and 48000 is then subtracted. On the other frames the bit is 1. The accumulator starts from 0 when the slot becomes ready.
- R4: When a slot requested on one frame strobe and its tag bit is set on the next strobe, `accept` for that slot pulses high for exactly one clock, in the cycle after that strobe.
- R5: A tag on a powered-up supported slot that did not request on the previous strobe is dropped (no `accept`). It sets that slot's `overrun` bit, which stays set until reset.
- R6: An on-demand slot requests only if `fifo_level` plus the sample accepted on the same strobe is below the FIFO depth (4 by default).
- R7: A powered-down slot reports `slotreq_n`=0. Its tags produce neither `accept` nor `overrun`.
- R8: An unsupported slot (slot 5 by default) always reports 0 and ignores its tags.
- R9: After `pwr_dn` for a slot is cleared, the slot reports 1 for `ready_delay` frames and then starts normal requests. Asserting `pwr_dn` again restarts the full delay.
- R10: The modem-class slot (slot 3 by default) works on demand whatever the value of `vra`.
- R11: The auxiliary-class slot (slot 2 by default) works on demand when `vrm`=1 and in fixed mode when `vrm`=0, independent of `vra`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_start | input | 1 | One-clock strobe at the start of each link frame |
| vra | input | 1 | On-demand mode for PCM-class slots |
| vrm | input | 1 | On-demand mode for auxiliary-class slots |
| tag_in | input | NUM_CH | Received valid-tag bit per slot, sampled with `frame_start` |
| pwr_dn | input | NUM_CH | Power-down control per slot |
| rate_in | input | NUM_CH*RATE_W | Programmed sample rate per slot, in Hz, slot n at bits [n*RATE_W +: RATE_W] |
| fifo_level | input | NUM_CH*LVL_W | FIFO occupancy per slot, same packing |
| ready_delay | input | CNT_W | Frames of "not ready" after power-up |
| slotreq_n | output | NUM_CH | Active-low request vector for the outgoing frame |
| accept | output | NUM_CH | One-clock write strobe into each slot's FIFO |
| overrun | output | NUM_CH | Sticky unrequested-sample flag per slot |

## Verification
The bench uses the default build: six slots made up of three PCM, one auxiliary, one modem and one unsupported slot. This puts every class and the unsupported case side by side in the same frames. A FIFO depth of 4 lets an occupancy of 3 reach the room limit in two frames. A 16-bit rate lets 48000, 24000 and 16000 Hz give short, known request patterns. An 8-bit delay set to 3 shows the full warm-up window and its restart in a handful of frames.

// File: rtl/vsr_pkg.sv
package vsr_pkg;

  // Link frame rate; the pacing accumulator wraps at this value.
  localparam int unsigned FRAME_HZ = 48000;

  typedef enum logic [1:0] {
    CLS_PCM   = 2'd0,
    CLS_AUX   = 2'd1,
    CLS_MODEM = 2'd2
  } slot_class_e;

endpackage

// File: rtl/vsr_rate_pacer.sv
module vsr_rate_pacer #(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              due
);

  localparam int ACC_W = RATE_W + 1;
  localparam logic [ACC_W-1:0] FRAME = ACC_W'(vsr_pkg::FRAME_HZ);

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W-1:0] rate_eff;
  logic [ACC_W-1:0] sum;

  always_comb begin
    rate_eff = ({1'b0, rate} > FRAME) ? FRAME : {1'b0, rate};
    sum      = acc_q + rate_eff;
    due      = (sum >= FRAME);
    acc_d    = acc_q;
    if (frame_start) begin
      if (!run)     acc_d = '0;
      else if (due) acc_d = sum - FRAME;
      else          acc_d = sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < FRAME); // R3

endmodule

// File: rtl/vsr_ready_timer.sv
module vsr_ready_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             pwr_dn,
  input  logic [CNT_W-1:0] delay,
  output logic             ready
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (pwr_dn)                        cnt_d = delay;
    else if (frame_start && cnt_q != '0) cnt_d = cnt_q - 1'b1;
    ready = (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_DELAY_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> cnt_q == $past(delay)); // R9

endmodule

// File: rtl/vsr_slot_ctrl.sv
module vsr_slot_ctrl #(
  parameter int          RATE_W    = 16,
  parameter int          LVL_W     = 3,
  parameter int          DEPTH     = 4,
  parameter int          CNT_W     = 8,
  parameter logic [1:0]  CLASS     = 2'd0,
  parameter logic        SUPPORTED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              vra,
  input  logic              vrm,
  input  logic              tag,
  input  logic              pwr_dn,
  input  logic [RATE_W-1:0] rate,
  input  logic [LVL_W-1:0]  level,
  input  logic [CNT_W-1:0]  delay,
  output logic              slotreq_n,
  output logic              accept,
  output logic              overrun
);

  import vsr_pkg::*;

  localparam logic [LVL_W:0] DEPTH_V = (LVL_W+1)'(DEPTH);

  logic sreq_q, sreq_d;
  logic pend_q, pend_d;
  logic acc_q,  acc_d;
  logic ovr_q,  ovr_d;

  logic act, ready, rdy, ondemand, due, take, drop, room, req;
  logic [LVL_W:0] lvl_sum;

  vsr_ready_timer #(.CNT_W(CNT_W)) i_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .pwr_dn      (pwr_dn),
    .delay       (delay),
    .ready       (ready)
  );

  vsr_rate_pacer #(.RATE_W(RATE_W)) i_pacer (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .run         (rdy & ondemand),
    .rate        (rate),
    .due         (due)
  );

  always_comb begin
    if (CLASS == CLS_MODEM)    ondemand = 1'b1;
    else if (CLASS == CLS_AUX) ondemand = vrm;
    else                       ondemand = vra;

    act     = SUPPORTED & ~pwr_dn;
    rdy     = act & ready;
    take    = rdy & tag & pend_q;
    drop    = act & tag & ~pend_q;
    lvl_sum = {1'b0, level} + {{LVL_W{1'b0}}, take};
    room    = (lvl_sum < DEPTH_V);
    req     = rdy & (ondemand ? (due & room) : 1'b1);

    sreq_d = sreq_q;
    pend_d = pend_q;
    ovr_d  = ovr_q;
    acc_d  = 1'b0;
    if (frame_start) begin
      sreq_d = act & ~req;
      pend_d = req;
      ovr_d  = ovr_q | drop;
      acc_d  = take;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreq_q <= 1'b0;
      pend_q <= 1'b0;
      acc_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      sreq_q <= sreq_d;
      pend_q <= pend_d;
      acc_q  <= acc_d;
      ovr_q  <= ovr_d;
    end
  end

  assign slotreq_n = sreq_q;
  assign accept    = acc_q;
  assign overrun   = ovr_q;

  AST_FIXED_EVERY_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && act && ready && !ondemand |=> !slotreq_n); // R2
  AST_ACCEPT_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $past(!slotreq_n)); // R4
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(overrun)); // R5
  AST_NO_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && act && ready && ondemand && ({1'b0, level} >= DEPTH_V) |=> slotreq_n); // R6
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && pwr_dn |=> !slotreq_n && !accept); // R7
  AST_WARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && act && !ready |=> slotreq_n); // R9

  if (!SUPPORTED) begin : g_unsup
    AST_UNSUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !slotreq_n && !accept && !overrun); // R8
  end

endmodule

// File: rtl/vsr_slot_req_top.sv
module vsr_slot_req_top #(
  parameter int                  NUM_CH    = 6,
  parameter int                  RATE_W    = 16,
  parameter int                  DEPTH     = 4,
  parameter int                  CNT_W     = 8,
  parameter logic [2*NUM_CH-1:0] CH_CLASS  = 12'b00_00_10_01_00_00,
  parameter logic [NUM_CH-1:0]   CH_SUPP   = 6'b011111,
  localparam int                 LVL_W     = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_start,
  input  logic                     vra,
  input  logic                     vrm,
  input  logic [NUM_CH-1:0]        tag_in,
  input  logic [NUM_CH-1:0]        pwr_dn,
  input  logic [NUM_CH*RATE_W-1:0] rate_in,
  input  logic [NUM_CH*LVL_W-1:0]  fifo_level,
  input  logic [CNT_W-1:0]         ready_delay,
  output logic [NUM_CH-1:0]        slotreq_n,
  output logic [NUM_CH-1:0]        accept,
  output logic [NUM_CH-1:0]        overrun
);

  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_n_int = rst_sync_q[1];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    vsr_slot_ctrl #(
      .RATE_W    (RATE_W),
      .LVL_W     (LVL_W),
      .DEPTH     (DEPTH),
      .CNT_W     (CNT_W),
      .CLASS     (CH_CLASS[2*g +: 2]),
      .SUPPORTED (CH_SUPP[g])
    ) i_slot (
      .clk         (clk),
      .rst_n       (rst_n_int),
      .frame_start (frame_start),
      .vra         (vra),
      .vrm         (vrm),
      .tag         (tag_in[g]),
      .pwr_dn      (pwr_dn[g]),
      .rate        (rate_in[g*RATE_W +: RATE_W]),
      .level       (fifo_level[g*LVL_W +: LVL_W]),
      .delay       (ready_delay),
      .slotreq_n   (slotreq_n[g]),
      .accept      (accept[g]),
      .overrun     (overrun[g])
    );
  end

endmodule

// File: tb/test_vsr_slot_req_top.sv
module test_vsr_slot_req_top;

  localparam int NCH = 6;
  localparam int RW  = 16;
  localparam int LW  = 3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            frame_start;
  logic            vra, vrm;
  logic [NCH-1:0]  tag_in, pwr_dn;
  logic [NCH*RW-1:0] rate_in;
  logic [NCH*LW-1:0] fifo_level;
  logic [7:0]      ready_delay;
  logic [NCH-1:0]  slotreq_n, accept, overrun;

  logic [NCH-1:0]  sr, ac;
  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  vsr_slot_req_top i_vsr_slot_req_top (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .vra(vra), .vrm(vrm),
    .tag_in(tag_in), .pwr_dn(pwr_dn), .rate_in(rate_in), .fifo_level(fifo_level),
    .ready_delay(ready_delay), .slotreq_n(slotreq_n), .accept(accept), .overrun(overrun)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic set_rate(input int ch, input int v);
    rate_in[ch*RW +: RW] = RW'(v);
  endtask

  task automatic set_lvl(input int ch, input int v);
    fifo_level[ch*LW +: LW] = LW'(v);
  endtask

  task automatic frame(input logic [NCH-1:0] tags);
    @(negedge clk);
    tag_in = tags;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    tag_in = '0;
    sr = slotreq_n;
    ac = accept;
  endtask

  task automatic restart_all();
    pwr_dn = '1;
    frame('0);
    pwr_dn = '0;
  endtask

  task automatic t_reset();
    chk("R1 slotreq_n", 32'(slotreq_n), 0);
    chk("R1 accept", 32'(accept), 0);
    chk("R1 overrun", 32'(overrun), 0);
  endtask

  task automatic t_fixed();
    vra = 1'b0; vrm = 1'b0;
    for (int c = 0; c < NCH; c++) set_rate(c, 8000);
    restart_all();
    frame('0);
    chk("R2 fixed slots request", 32'(sr), 32'(6'b001000));
    set_rate(0, 0);
    frame(6'b000001);
    chk("R2 rate ignored", 32'(sr), 32'(6'b001000));
    chk("R2 fixed sample taken", 32'(ac), 32'(6'b000001));
    chk("R2 no overrun", 32'(overrun), 0);
  endtask

  task automatic t_pacing();
    int racc [NCH];
    logic [NCH-1:0] exp;
    vra = 1'b1; vrm = 1'b0;
    set_rate(0, 24000); set_rate(1, 48000); set_rate(2, 8000);
    set_rate(3, 8000);  set_rate(4, 16000);
    for (int c = 0; c < NCH; c++) racc[c] = 0;
    restart_all();
    for (int f = 0; f < 6; f++) begin
      frame('0);
      exp = '0;
      for (int c = 0; c < NCH; c++) begin
        if (c == 0 || c == 1 || c == 3 || c == 4) begin
          racc[c] += int'(rate_in[c*RW +: RW]);
          if (racc[c] >= 48000) racc[c] -= 48000;
          else exp[c] = 1'b1;
        end
      end
      chk("R3 paced requests", 32'(sr), 32'(exp));
    end
  endtask

  task automatic t_handshake();
    vra = 1'b1; vrm = 1'b0;
    for (int c = 0; c < NCH; c++) set_rate(c, 0);
    set_rate(0, 48000);
    restart_all();
    frame('0);
    chk("R4 request raised", 32'(sr), 32'(6'b011010));
    frame(6'b000001);
    chk("R4 accept pulse", 32'(ac), 32'(6'b000001));
    @(negedge clk);
    chk("R4 accept one clock", 32'(accept), 0);
    chk("R4 no overrun", 32'(overrun[0]), 0);
  endtask

  task automatic t_overrun();
    frame(6'b010000);
    chk("R5 unrequested dropped", 32'(ac[4]), 0);
    chk("R5 overrun set", 32'(overrun), 32'(6'b010000));
    frame('0);
    chk("R5 overrun sticky", 32'(overrun), 32'(6'b010000));
  endtask

  task automatic t_room();
    vra = 1'b1;
    set_rate(0, 48000);
    set_lvl(0, 3);
    restart_all();
    frame('0);
    chk("R6 room for one", 32'(sr[0]), 0);
    frame(6'b000001);
    chk("R6 accepted sample", 32'(ac[0]), 1);
    chk("R6 in-flight fills FIFO", 32'(sr[0]), 1);
    set_lvl(0, 4);
    frame('0);
    chk("R6 FIFO full", 32'(sr[0]), 1);
    set_lvl(0, 3);
    frame('0);
    chk("R6 room again", 32'(sr[0]), 0);
    set_lvl(0, 0);
  endtask

  task automatic t_powerdown();
    vra = 1'b1;
    set_rate(0, 48000);
    pwr_dn = 6'b000001;
    frame(6'b000001);
    chk("R7 off slot reads 0", 32'(sr[0]), 0);
    frame(6'b000001);
    chk("R7 off tag ignored", 32'(ac[0]), 0);
    chk("R7 off no overrun", 32'(overrun[0]), 0);
    pwr_dn = '0;
  endtask

  task automatic t_unsupported();
    set_rate(5, 48000);
    for (int f = 0; f < 2; f++) begin
      frame(6'b100000);
      chk("R8 unsupported reads 0", 32'(sr[5]), 0);
      chk("R8 unsupported no accept", 32'(ac[5]), 0);
    end
    chk("R8 unsupported no overrun", 32'(overrun[5]), 0);
  endtask

  task automatic t_warmup();
    vra = 1'b1;
    set_rate(1, 48000);
    ready_delay = 8'd3;
    pwr_dn[1] = 1'b1;
    frame('0);
    chk("R9 off before warm-up", 32'(sr[1]), 0);
    pwr_dn[1] = 1'b0;
    for (int f = 0; f < 3; f++) begin
      frame('0);
      chk("R9 not ready held 1", 32'(sr[1]), 1);
    end
    frame('0);
    chk("R9 ready requests", 32'(sr[1]), 0);
    pwr_dn[1] = 1'b1;
    frame('0);
    pwr_dn[1] = 1'b0;
    for (int f = 0; f < 2; f++) frame('0);
    pwr_dn[1] = 1'b1;
    frame('0);
    chk("R9 re-off reads 0", 32'(sr[1]), 0);
    pwr_dn[1] = 1'b0;
    for (int f = 0; f < 3; f++) begin
      frame('0);
      chk("R9 delay restarted", 32'(sr[1]), 1);
    end
    frame('0);
    chk("R9 ready after restart", 32'(sr[1]), 0);
    ready_delay = 8'd0;
  endtask

  task automatic t_modem();
    set_rate(3, 24000);
    set_rate(0, 48000);
    for (int v = 0; v < 2; v++) begin
      vra = v[0]; vrm = 1'b0;
      restart_all();
      for (int f = 0; f < 4; f++) begin
        frame('0);
        chk("R10 modem on demand", 32'(sr[3]), 32'((f % 2) == 0));
      end
    end
  endtask

  task automatic t_aux();
    vra = 1'b0; vrm = 1'b1;
    set_rate(2, 24000);
    restart_all();
    for (int f = 0; f < 4; f++) begin
      frame('0);
      chk("R11 aux on demand", 32'(sr[2]), 32'((f % 2) == 0));
      chk("R11 PCM stays fixed", 32'(sr[0]), 0);
    end
    vrm = 1'b0; vra = 1'b1;
    frame('0);
    chk("R11 aux fixed with vrm=0", 32'(sr[2]), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    frame_start = 1'b0;
    vra = 1'b0; vrm = 1'b0;
    tag_in = '0;
    pwr_dn = '1;
    rate_in = '0;
    fifo_level = '0;
    ready_delay = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    pwr_dn = '0;
    t_fixed();
    t_pacing();
    t_handshake();
    t_overrun();
    t_room();
    t_powerdown();
    t_unsupported();
    t_warmup();
    t_modem();
    t_aux();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

endmodule